// File: doc/BRIEF.md
# TLB range invalidation controller

This block removes stale translations from a small translation cache. The cache is shared by up to two translation units. Software programs a unit mask, a start address and an inclusive end address over a simple register bus. It then writes one command word. That word asks for either a range invalidation or a full invalidation. A range invalidation walks the cache one entry per clock. It clears every valid entry, in the selected units, whose stored virtual page number lies between the start and end page numbers. Pages are 4 KB, so the page number is the address shifted right by `PAGE_SHIFT`.

When the walk finishes, a sticky completion flag rises. Software polls that flag and clears it by writing zero. Software may give up waiting and fall back to a full invalidation. For that reason a full invalidation is accepted at any moment, including while a walk is running. A full invalidation clears the selected units in a single cycle and leaves the completion flag alone.

The cache model is direct-mapped. A fill port writes an entry at index `vpn[IDX_W-1:0]`, and a probe port answers whether a page is present. The bench uses these two ports to set up state and to observe the effect of each invalidation.

The register bus is valid/ready. A request transfers on a cycle where `req_valid` and `req_ready` are both high. A read returns its data with `rsp_valid` one cycle after it is accepted. `rsp_valid` and `rsp_rdata` then hold until `rsp_ready` is high. `req_ready` is low only while a response is waiting with `rsp_ready` low. Writes produce no response.

Register map (word address `req_addr`):

| Address | Name | Write | Read |
|---|---|---|---|
| 0 | SEL | bits[UNITS-1:0] form the unit mask | the mask |
| 1 | START | range start address | start |
| 2 | END | inclusive range end address | end |
| 3 | CMD | 1 starts a range walk; 2 starts a full invalidation | bit0 = busy |
| 4 | DONE | 0 clears the flag | bit0 = done |

Top module: `tlbinv_ctrl`

## Requirements
- R1: After reset the SEL, START and END registers read 0. CMD reads 0 (not busy) and DONE reads 0. No cache entry hits and `rsp_valid` is low.
- R2: A read accepted on one clock edge shows `rsp_valid` high with its data after that edge. While `rsp_ready` is low, `rsp_valid` and `rsp_rdata` stay unchanged and `req_ready` is low.
- R3: Writing 1 to CMD (address 3) while idle clears, in the selected units, each valid entry whose page number p satisfies START>>12 <= p <= END>>12. The end bound is inclusive. All other entries keep their state.
- R4: A range walk visits one entry per clock and lasts ENTRIES cycles. During the walk CMD bit0 reads 1, and any further write of 1 to CMD is ignored.
- R5: When a walk completes, DONE bit0 reads 1. It stays 1 until a write of value 0 to DONE (address 4). Writes of nonzero values to DONE have no effect. If completion and clear fall on the same cycle, completion wins.
- R6: Writing 2 to CMD invalidates every entry of the units selected in SEL by the next cycle. This holds even during a range walk. It does not stop that walk and does not set DONE.
- R7: SEL bit u targets unit u (bit 0 for unit 0, bit 1 for unit 1). Unselected units are untouched. The mask, START and END are captured when a walk starts, so later register writes do not alter that walk.
- R8: CMD values other than 1 and 2 start nothing: busy stays 0, no entry changes and DONE is unchanged.
- R9: A range whose start page is above its end page clears nothing, yet still completes and sets DONE.
- R10: A fill writes its unit's entry at index `vpn[IDX_W-1:0]` as valid with that page number. The probe hits only when that index is valid and holds the same page number. An invalidation of the same entry in the same cycle wins over a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Requester takes read data |
| rsp_rdata | output | DW | Read data |
| fill_en | input | 1 | Write one cache entry |
| fill_unit | input | UW | Unit receiving the fill |
| fill_vpn | input | DW-PAGE_SHIFT | Page number to install |
| probe_unit | input | UW | Unit to look up |
| probe_vpn | input | DW-PAGE_SHIFT | Page number to look up |
| probe_hit | output | 1 | Page present in that unit |

## Verification
The following are checked on every cycle:
- response stability under back-pressure;
- the walk index stepping by one while busy, so a re-trigger cannot restart it;
- completion following the last step;
- the done flag holding until a zero write;
- a full invalidation emptying each selected unit without touching done;
- unknown commands leaving the engine idle.

Which entries a range actually removes, the inclusive end page, start-above-end ranges, mask capture at walk start and the interplay of a full invalidation arriving mid-walk are shown only by the bench scenarios, which observe the cache through the probe port.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;
  localparam logic [2:0] RA_SEL   = 3'd0;
  localparam logic [2:0] RA_START = 3'd1;
  localparam logic [2:0] RA_END   = 3'd2;
  localparam logic [2:0] RA_CMD   = 3'd3;
  localparam logic [2:0] RA_DONE  = 3'd4;
  localparam int unsigned CMD_RANGE = 1;
  localparam int unsigned CMD_FULL  = 2;
endpackage

// File: rtl/tlbinv_regs.sv
module tlbinv_regs
  import tlbinv_pkg::*;
#(
  parameter int DW    = 32,
  parameter int UNITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [2:0]       req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_rdata,
  input  logic             busy_i,
  input  logic             walk_fin_i,
  output logic [UNITS-1:0] sel_o,
  output logic [DW-1:0]    start_o,
  output logic [DW-1:0]    end_o,
  output logic             range_go_o,
  output logic             full_go_o,
  output logic             done_o
);
  logic          wr_acc, rd_acc, done_clr;
  logic [DW-1:0] rd_mux;

  assign req_ready  = !(rsp_valid && !rsp_ready);
  assign wr_acc     = req_valid && req_ready && req_write;
  assign rd_acc     = req_valid && req_ready && !req_write;
  assign range_go_o = wr_acc && req_addr == RA_CMD && req_wdata == DW'(CMD_RANGE) && !busy_i;
  assign full_go_o  = wr_acc && req_addr == RA_CMD && req_wdata == DW'(CMD_FULL);
  assign done_clr   = wr_acc && req_addr == RA_DONE && req_wdata == '0;

  always_comb begin
    case (req_addr)
      RA_SEL:   rd_mux = DW'(sel_o);
      RA_START: rd_mux = start_o;
      RA_END:   rd_mux = end_o;
      RA_CMD:   rd_mux = DW'(busy_i);
      RA_DONE:  rd_mux = DW'(done_o);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_o   <= '0;
      start_o <= '0;
      end_o   <= '0;
    end else if (wr_acc) begin
      if (req_addr == RA_SEL)   sel_o   <= req_wdata[UNITS-1:0];
      if (req_addr == RA_START) start_o <= req_wdata;
      if (req_addr == RA_END)   end_o   <= req_wdata;
    end
  end

  // completion has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          done_o <= 1'b0;
    else if (walk_fin_i) done_o <= 1'b1;
    else if (done_clr)   done_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tlbinv_walker.sv
module tlbinv_walker #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int UNITS   = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             range_go,
  input  logic [UNITS-1:0] sel,
  input  logic [VPN_W-1:0] start_vpn,
  input  logic [VPN_W-1:0] end_vpn,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic [UNITS-1:0] mask,
  output logic [VPN_W-1:0] lo_vpn,
  output logic [VPN_W-1:0] hi_vpn,
  output logic             fin
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  assign fin = busy && idx == LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      mask   <= '0;
      lo_vpn <= '0;
      hi_vpn <= '0;
    end else if (range_go) begin
      busy   <= 1'b1;
      idx    <= '0;
      mask   <= sel;
      lo_vpn <= start_vpn;
      hi_vpn <= end_vpn;
    end else if (busy) begin
      if (idx == LAST) busy <= 1'b0;
      else             idx  <= idx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/tlbinv_tlb.sv
module tlbinv_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic               flush_all,
  input  logic               walk_en,
  input  logic [IDX_W-1:0]   walk_idx,
  input  logic [VPN_W-1:0]   lo_vpn,
  input  logic [VPN_W-1:0]   hi_vpn,
  input  logic [VPN_W-1:0]   probe_vpn,
  output logic               probe_hit,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [VPN_W-1:0] tag_q [ENTRIES];
  logic [IDX_W-1:0] fill_idx, probe_idx;
  logic             walk_kill;

  assign fill_idx  = fill_vpn[IDX_W-1:0];
  assign probe_idx = probe_vpn[IDX_W-1:0];
  assign walk_kill = walk_en && valid_vec[walk_idx] &&
                     tag_q[walk_idx] >= lo_vpn && tag_q[walk_idx] <= hi_vpn;
  assign probe_hit = valid_vec[probe_idx] && tag_q[probe_idx] == probe_vpn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_vec <= '0;
    end else if (flush_all) begin
      valid_vec <= '0;
    end else begin
      if (fill_en)   valid_vec[fill_idx] <= 1'b1;
      if (walk_kill) valid_vec[walk_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_vpn;
  end
endmodule

// File: rtl/tlbinv_ctrl.sv
module tlbinv_ctrl #(
  parameter int DW         = 32,
  parameter int UNITS      = 2,
  parameter int ENTRIES    = 16,
  parameter int PAGE_SHIFT = 12,
  localparam int UW        = (UNITS > 1) ? $clog2(UNITS) : 1,
  localparam int VPN_W     = DW - PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [2:0]       req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_rdata,
  input  logic             fill_en,
  input  logic [UW-1:0]    fill_unit,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [UW-1:0]    probe_unit,
  input  logic [VPN_W-1:0] probe_vpn,
  output logic             probe_hit
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [UNITS-1:0]         sel_q, walk_mask, hit_vec;
  logic [DW-1:0]            start_q, end_q;
  logic                     range_go, full_go, walk_busy, walk_fin, done_flag;
  logic [IDX_W-1:0]         walk_idx;
  logic [VPN_W-1:0]         lo_vpn, hi_vpn;
  logic [UNITS*ENTRIES-1:0] vld_all;

  tlbinv_regs #(.DW(DW), .UNITS(UNITS)) u_regs (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_ready, .rsp_rdata,
    .busy_i(walk_busy), .walk_fin_i(walk_fin), .sel_o(sel_q),
    .start_o(start_q), .end_o(end_q), .range_go_o(range_go),
    .full_go_o(full_go), .done_o(done_flag)
  );

  tlbinv_walker #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .UNITS(UNITS)) u_walk (
    .clk, .rst_n, .range_go, .sel(sel_q),
    .start_vpn(start_q[DW-1:PAGE_SHIFT]), .end_vpn(end_q[DW-1:PAGE_SHIFT]),
    .busy(walk_busy), .idx(walk_idx), .mask(walk_mask),
    .lo_vpn, .hi_vpn, .fin(walk_fin)
  );

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    tlbinv_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_tlb (
      .clk, .rst_n,
      .fill_en(fill_en && fill_unit == UW'(u)),
      .fill_vpn,
      .flush_all(full_go && sel_q[u]),
      .walk_en(walk_busy && walk_mask[u]),
      .walk_idx, .lo_vpn, .hi_vpn, .probe_vpn,
      .probe_hit(hit_vec[u]),
      .valid_vec(vld_all[u*ENTRIES +: ENTRIES])
    );
  end

  assign probe_hit = hit_vec[probe_unit];
endmodule

// File: rtl/tlbinv_ctrl_chk.sv
module tlbinv_ctrl_chk
  import tlbinv_pkg::*;
#(
  parameter int DW      = 32,
  parameter int UNITS   = 2,
  parameter int ENTRIES = 16,
  parameter int UW      = 1,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     req_write,
  input logic [2:0]               req_addr,
  input logic [DW-1:0]            req_wdata,
  input logic                     rsp_valid,
  input logic                     rsp_ready,
  input logic [DW-1:0]            rsp_rdata,
  input logic                     fill_en,
  input logic [UW-1:0]            fill_unit,
  input logic                     busy,
  input logic                     walk_fin,
  input logic                     done,
  input logic [UNITS-1:0]         sel_q,
  input logic [IDX_W-1:0]         walk_idx,
  input logic [UNITS*ENTRIES-1:0] vld_all
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic wr_acc, cmd_full, cmd_other, done_zero;
  assign wr_acc    = req_valid && req_ready && req_write;
  assign cmd_full  = wr_acc && req_addr == RA_CMD && req_wdata == DW'(CMD_FULL);
  assign cmd_other = wr_acc && req_addr == RA_CMD &&
                     req_wdata != DW'(CMD_FULL) && req_wdata != DW'(CMD_RANGE);
  assign done_zero = wr_acc && req_addr == RA_DONE && req_wdata == '0;

  // R2: a stalled response holds its data
  a_r2_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R4: walk advances by one each cycle; re-triggers cannot restart it
  a_r4_walk_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy && walk_idx != LAST |=> busy && walk_idx == $past(walk_idx) + IDX_W'(1));

  // R5: completion raises done
  a_r5_done_on_fin: assert property (@(posedge clk) disable iff (!rst_n)
    walk_fin |=> done);

  // R5: done is sticky until a zero write
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_zero |=> done);

  // R6: full invalidation does not raise done
  a_r6_full_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_full && !done && !walk_fin |=> !done);

  // R6: full invalidation empties each selected unit
  for (genvar u = 0; u < UNITS; u++) begin : g_full
    a_r6_full_empty: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_full && sel_q[u] && !(fill_en && fill_unit == UW'(u))
      |=> vld_all[u*ENTRIES +: ENTRIES] == '0);
  end

  // R8: unknown command leaves the engine idle
  a_r8_other_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_other && !busy |=> !busy);
endmodule

bind tlbinv_ctrl tlbinv_ctrl_chk #(
  .DW(DW), .UNITS(UNITS), .ENTRIES(ENTRIES), .UW(UW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .fill_en(fill_en), .fill_unit(fill_unit), .busy(walk_busy),
  .walk_fin(walk_fin), .done(done_flag), .sel_q(sel_q),
  .walk_idx(walk_idx), .vld_all(vld_all)
);

// File: tb/sim_tlbinv_ctrl.sv
module sim_tlbinv_ctrl;
  localparam int DW = 32;
  localparam int VPN_W = 20;
  localparam logic [2:0] A_SEL = 3'd0, A_START = 3'd1, A_END = 3'd2,
                         A_CMD = 3'd3, A_DONE = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1, fill_en = 0;
  logic [2:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic fill_unit = 0, probe_unit = 0;
  logic [VPN_W-1:0] fill_vpn = '0, probe_vpn = '0;
  logic req_ready, rsp_valid, probe_hit;
  logic [DW-1:0] rsp_rdata;
  int vecs = 0, errs = 0;

  always #2 clk = ~clk;

  tlbinv_ctrl u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_ready, .rsp_rdata, .fill_en, .fill_unit, .fill_vpn,
    .probe_unit, .probe_vpn, .probe_hit
  );

  // {sel[1:0], start[31:0], end[31:0]}
  localparam logic [65:0] VEC [8] = '{
    {2'd1, 32'h0001_0000, 32'h0001_FFFF},  // R3 all of unit 0
    {2'd3, 32'h0001_3000, 32'h0001_3000},  // R3 single page, inclusive end
    {2'd3, 32'h0001_2800, 32'h0002_5FFF},  // R3 spans both units
    {2'd1, 32'h0002_0000, 32'h0002_FFFF},  // R7 unit 1 unselected
    {2'd3, 32'h0002_5000, 32'h0002_0000},  // R9 start above end
    {2'd0, 32'h0000_0000, 32'hFFFF_FFFF},  // R7 empty mask
    {2'd2, 32'h0000_0000, 32'hFFFF_FFFF},  // R7 unit 1 only
    {2'd3, 32'h0001_F000, 32'h0002_0FFF}   // R3 boundary pages
  };

  function automatic logic [VPN_W-1:0] vpn_of(int u, int i);
    return VPN_W'((u + 1) * 16 + i);
  endfunction

  function automatic logic [31:0] model(logic [1:0] sel, logic [31:0] lo, logic [31:0] hi);
    logic [31:0] m = '1;
    for (int u = 0; u < 2; u++)
      for (int i = 0; i < 16; i++)
        if (sel[u] && 32'(vpn_of(u, i)) >= (lo >> 12) && 32'(vpn_of(u, i)) <= (hi >> 12))
          m[u*16+i] = 1'b0;
    return m;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk); req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk); req_valid = 0; d = rsp_rdata;
  endtask

  task automatic fill(int u, logic [VPN_W-1:0] v);
    @(negedge clk); fill_en = 1; fill_unit = u[0]; fill_vpn = v;
    @(negedge clk); fill_en = 0;
  endtask

  task automatic fill_all();
    for (int u = 0; u < 2; u++)
      for (int i = 0; i < 16; i++) fill(u, vpn_of(u, i));
  endtask

  task automatic probe(int u, logic [VPN_W-1:0] v, output logic h);
    @(negedge clk); probe_unit = u[0]; probe_vpn = v; #1; h = probe_hit;
  endtask

  task automatic snapshot(output logic [31:0] m);
    logic h;
    for (int u = 0; u < 2; u++)
      for (int i = 0; i < 16; i++) begin
        probe(u, vpn_of(u, i), h);
        m[u*16+i] = h;
      end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vecs++; errs++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [31:0] d, m;
    logic h;
    idle(3); rst_n = 1; idle(1);

    // R1 reset state
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    bus_rd(A_SEL, d);   check("R1 sel", d, 0);
    bus_rd(A_START, d); check("R1 start", d, 0);
    bus_rd(A_END, d);   check("R1 end", d, 0);
    bus_rd(A_CMD, d);   check("R1 busy", d, 0);
    bus_rd(A_DONE, d);  check("R1 done", d, 0);
    snapshot(m);        check("R1 empty cache", m, 0);

    // R10 fill and probe
    fill(0, 20'h35);
    probe(0, 20'h35, h); check("R10 hit", 32'(h), 1);
    probe(0, 20'h45, h); check("R10 tag mismatch", 32'(h), 0);
    probe(1, 20'h35, h); check("R10 other unit", 32'(h), 0);

    // vector table: R3 R5 R7 R9
    for (int v = 0; v < 8; v++) begin
      fill_all();
      bus_wr(A_SEL, 32'(VEC[v][65:64]));
      bus_wr(A_START, VEC[v][63:32]);
      bus_wr(A_END, VEC[v][31:0]);
      bus_wr(A_CMD, 1);
      idle(20);
      bus_rd(A_DONE, d); check("R5 done after walk", d, 1);
      snapshot(m);
      check("R3 range result", m, model(VEC[v][65:64], VEC[v][63:32], VEC[v][31:0]));
      bus_wr(A_DONE, 0);
    end

    // R4 busy, re-trigger ignored, R7 registers captured at start
    fill_all();
    bus_wr(A_SEL, 1); bus_wr(A_START, 32'h0001_0000); bus_wr(A_END, 32'h0001_0FFF);
    bus_wr(A_CMD, 1);
    bus_rd(A_CMD, d);  check("R4 busy during walk", d, 1);
    bus_rd(A_DONE, d); check("R4 walk not instant", d, 0);
    bus_wr(A_END, 32'h0001_FFFF); bus_wr(A_CMD, 1);
    idle(40);
    bus_rd(A_CMD, d); check("R4 idle after walk", d, 0);
    snapshot(m); check("R4 retrigger ignored", m, 32'hFFFF_FFFE);

    // R5 sticky done
    bus_wr(A_DONE, 5);
    bus_rd(A_DONE, d); check("R5 nonzero write ignored", d, 1);
    bus_wr(A_DONE, 0);
    bus_rd(A_DONE, d); check("R5 zero write clears", d, 0);

    // R6 full during walk
    fill_all();
    bus_wr(A_SEL, 1); bus_wr(A_START, 32'h0001_0000); bus_wr(A_END, 32'h0001_0FFF);
    bus_wr(A_CMD, 1);
    bus_wr(A_SEL, 2); bus_wr(A_CMD, 2);
    idle(40);
    snapshot(m); check("R6 full during walk", m, 32'h0000_FFFE);
    bus_rd(A_DONE, d); check("R6 walk still completes", d, 1);
    bus_wr(A_DONE, 0);

    // R6 full alone
    fill_all();
    bus_wr(A_SEL, 3); bus_wr(A_CMD, 2);
    idle(3);
    snapshot(m); check("R6 full clears all", m, 0);
    bus_rd(A_DONE, d); check("R6 full leaves done", d, 0);

    // R8 unknown commands
    fill_all();
    bus_wr(A_CMD, 3);
    bus_rd(A_CMD, d); check("R8 cmd 3 not busy", d, 0);
    bus_wr(A_CMD, 0);
    idle(20);
    snapshot(m); check("R8 entries kept", m, 32'hFFFF_FFFF);
    bus_rd(A_DONE, d); check("R8 done unchanged", d, 0);

    // R2 back-pressure
    @(negedge clk); rsp_ready = 0;
    bus_rd(A_SEL, d);
    check("R2 req_ready low when stalled", 32'(req_ready), 0);
    check("R2 read data", d, 3);
    idle(3);
    check("R2 rsp_valid held", 32'(rsp_valid), 1);
    check("R2 rsp_rdata held", rsp_rdata, 3);
    rsp_ready = 1;
    @(negedge clk);
    check("R2 rsp released", 32'(rsp_valid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule